// File: doc/BRIEF.md
# One-Second Errored-Second Status Monitor

This block watches a stream of per-cycle strobes from a line receiver: one strobe marks each bit that was observed, another marks each detected error. It sums both over one-second windows whose edges come from an external once-per-second tick. When a window closes, the block decides whether that second was errored (at least one error) and whether it was severely errored (the errors exceeded one per thousand observed bits). It then publishes both decisions in a read-only status byte.

The status byte changes only on the tick. Between ticks it always shows the verdict on the last completed window. The window that is open when reset is released is not complete, so the first tick after reset publishes zeros. Later ticks publish real verdicts. The tick source and the error detector sit outside this block.

Top module: `err_sec_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until a tick publishes a verdict, `statusByte` reads 0x00.
- R2: Bits 7 down to 2 of `statusByte` always read zero.
- R3: Bit 1 of `statusByte` (errored second) is 1 after a tick exactly when the window that the tick closed held one or more error strobes. Otherwise it is 0.
- R4: Bit 0 of `statusByte` (severely errored second) is 1 after a tick exactly when error_count × 1000 > bit_count for the closed window. It is never 1 while bit 1 is 0. Exactly one error in 1000 bits gives 0. One error in 999 bits gives 1. Errors with no bits give 1.
- R5: `statusByte` changes only on the clock edge that samples `tickSec` high, and holds its value on every other cycle.
- R6: An error or bit strobe that is high in the same cycle as `tickSec` counts toward the window that begins there, not the one that closes.
- R7: The first tick after reset publishes 0x00, whatever strobes arrived before it. Verdicts start with the second tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSec | input | 1 | One-cycle pulse that closes a one-second window |
| errStb | input | 1 | One detected error in this cycle |
| bitVld | input | 1 | One observed bit in this cycle |
| statusByte | output | 8 | Bit 1 errored second, bit 0 severely errored second, rest zero |

## Verification
The windows are built to separate the two flags:
- An error-free window shows that bit 1 is not raised spuriously.
- Sparse errors over many bits raise only bit 1.
- The pair of 1-in-1000 and 1-in-999 windows pins down the strict inequality of the ratio test.
- A window with errors but no bits shows that the ratio test does not depend on bits being present.

Strobes are placed on the tick cycle and then followed by windows with no other activity. These show whether those strobes land in the new window. The first window after reset carries errors, which tells a design that publishes it apart from one that suppresses it. Every cycle between ticks is compared against the last verdict, which catches flags that move off the tick.

// File: rtl/esm_pkg.sv
package esm_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clearAcc;    // restart both accumulators
    logic latchFlags;  // publish verdict on the closing window
  } ctrlStrobes_t;
endpackage

// File: rtl/esm_ctrl.sv
module esm_ctrl
  import esm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickSec,
  output ctrlStrobes_t strobes
);
  logic seenTick;  // a full window exists once the first tick has passed

  always_ff @(posedge clk) begin
    if (!rstN) seenTick <= 1'b0;
    else if (tickSec) seenTick <= 1'b1;
  end

  always_comb begin
    strobes.clearAcc   = tickSec;
    strobes.latchFlags = tickSec & seenTick;
  end
endmodule

// File: rtl/esm_datapath.sv
module esm_datapath
  import esm_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32,
  parameter int RATIO = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         errStb,
  input  logic         bitVld,
  output logic         esFlag,
  output logic         sesFlag
);
  localparam int RATIO_W = $clog2(RATIO + 1);
  localparam int PROD_W  = ERR_W + RATIO_W;
  localparam int CMP_W   = ((PROD_W > BIT_W) ? PROD_W : BIT_W) + 1;

  logic [ERR_W-1:0] errCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CMP_W-1:0] scaledErr;
  logic [CMP_W-1:0] bitWide;

  // saturating accumulators; tick-cycle strobes seed the new window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt <= '0;
      bitCnt <= '0;
    end else if (strobes.clearAcc) begin
      errCnt <= ERR_W'(errStb);
      bitCnt <= BIT_W'(bitVld);
    end else begin
      if (errStb && errCnt != '1) errCnt <= errCnt + 1'b1;
      if (bitVld && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    scaledErr = CMP_W'(errCnt) * CMP_W'(RATIO);
    bitWide   = CMP_W'(bitCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      esFlag  <= 1'b0;
      sesFlag <= 1'b0;
    end else if (strobes.latchFlags) begin
      esFlag  <= (errCnt != '0);
      sesFlag <= (scaledErr > bitWide);
    end
  end

  assert_tick_seed_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> (errCnt == ERR_W'($past(errStb))) && (bitCnt == BIT_W'($past(bitVld))));

  assert_hold_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchFlags |=> $stable(esFlag) && $stable(sesFlag));

  assert_ses_needs_es_R4: assert property (@(posedge clk) disable iff (!rstN)
    sesFlag |-> esFlag);

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt != '0) && !strobes.clearAcc |=> errCnt != '0);
endmodule

// File: rtl/err_sec_monitor.sv
module err_sec_monitor
  import esm_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32,
  parameter int RATIO = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickSec,
  input  logic       errStb,
  input  logic       bitVld,
  output logic [7:0] statusByte
);
  ctrlStrobes_t strobes;
  logic esFlag;
  logic sesFlag;

  esm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickSec (tickSec),
    .strobes (strobes)
  );

  esm_datapath #(.ERR_W(ERR_W), .BIT_W(BIT_W), .RATIO(RATIO)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .errStb  (errStb),
    .bitVld  (bitVld),
    .esFlag  (esFlag),
    .sesFlag (sesFlag)
  );

  assign statusByte = {6'b0, esFlag, sesFlag};

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tickSec |=> $stable(statusByte));
endmodule

// File: tb/err_sec_monitor_test.sv
module err_sec_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickSec = 1'b0;
  logic errStb = 1'b0;
  logic bitVld = 1'b0;
  logic [7:0] statusByte;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit seenTickTb = 0;
  int carryErr = 0;
  int carryBit = 0;
  logic [7:0] curExp = 8'h00;

  err_sec_monitor uut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec),
    .errStb(errStb), .bitVld(bitVld), .statusByte(statusByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one window then its closing tick; push the verdict that tick publishes
  task automatic runInterval(input int nBits, input int nErrs,
                             input bit errOnTick, input bit bitOnTick, input string tag);
    int span = (nBits > nErrs) ? nBits : nErrs;
    longint totErr;
    longint totBit;
    expItem_t item;
    for (int c = 0; c < span; c++) begin
      @(negedge clk);
      tickSec = 1'b0;
      bitVld  = (c < nBits);
      errStb  = (c < nErrs);
    end
    totErr = carryErr + nErrs;
    totBit = carryBit + nBits;
    if (!seenTickTb) item.val = 8'h00;
    else item.val = {6'b0, (totErr > 0), (totErr * 1000 > totBit)};
    item.tag = tag;
    expQ.push_back(item);
    seenTickTb = 1;
    @(negedge clk);
    tickSec = 1'b1;
    errStb  = errOnTick;
    bitVld  = bitOnTick;
    carryErr = errOnTick ? 1 : 0;
    carryBit = bitOnTick ? 1 : 0;
    @(negedge clk);
    tickSec = 1'b0;
    errStb  = 1'b0;
    bitVld  = 1'b0;
  endtask

  // monitor: compare on tick edges against the queue, else against held verdict
  initial begin
    bit t;
    expItem_t item;
    wait (rstN === 1'b1);
    forever begin
      @(posedge clk);
      t = tickSec;
      @(negedge clk);
      if (t) begin
        if (expQ.size() == 0) begin
          check(statusByte, curExp, "R5 unexpected tick");
        end else begin
          item = expQ.pop_front();
          curExp = item.val;
          check(statusByte, item.val, item.tag);
        end
      end else begin
        check(statusByte, curExp, "R5 hold between ticks / R2 upper bits");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, strobes active during reset must not matter
    repeat (3) begin
      @(negedge clk);
      errStb = 1'b1;
      bitVld = 1'b1;
      check(statusByte, 8'h00, "R1 during reset");
    end
    @(negedge clk);
    errStb = 1'b0;
    bitVld = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(statusByte, 8'h00, "R1 after reset release");

    runInterval(10, 5, 0, 0, "R7 first window suppressed");
    runInterval(2000, 0, 0, 0, "R3 error-free window");
    runInterval(2000, 1, 0, 0, "R3 single error sparse");
    runInterval(1000, 1, 0, 0, "R4 exactly 1 in 1000 not severe");
    runInterval(999, 1, 0, 0, "R4 1 in 999 severe");
    runInterval(0, 1, 0, 0, "R4 error with no bits");
    runInterval(3000, 3, 1, 0, "R4 3 in 3000 with tick error carried");
    runInterval(0, 0, 0, 1, "R6 tick error lands in new window");
    runInterval(999, 1, 0, 0, "R6 tick bit lands in new window");
    runInterval(5000, 6, 0, 0, "R4 6 in 5000 severe");
    runInterval(50, 0, 0, 0, "R3 clean after severe");

    repeat (5) @(negedge clk);
    check(8'(expQ.size()), 8'h00, "R5 all verdicts observed");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule